// File: doc/BRIEF.md
# Mode-Dependent Serial Flash Clock Generator

This block turns a system clock of known frequency into the serial clock for a flash device. The fastest clock the flash accepts depends on two things: the bus width in use (one, two or four data lines) and how many dummy cycles the read command inserts. The block looks up that ceiling and divides the system clock by the smallest whole ratio that keeps the serial clock at or below it. The ceilings are turned into divide ratios when the design is elaborated, using the system frequency parameter, so at run time the selection is only a table lookup.

When the ceiling is not below the system frequency, no division is needed. The block then routes the system clock straight to its output and raises a flag, so the transaction logic knows the serial clock runs at the full system rate. A new mode or dummy count is only picked up when the current output period ends, so switching never produces a shortened pulse.

Top module: `spiclk_gen`

## Requirements
- R1: Bus width is decoded from two enables: `single_en_i` high selects one data line, whatever `dual_en_i` is; `dual_en_i` high with `single_en_i` low selects two lines; both low select four lines.
- R2: `dummy_i` is a 4-bit count; the values 0 to 14 index the table, and 15 is handled exactly as 14.
- R3: With one data line the ceiling in MHz for dummy counts 0, 1, 2, 3 is 133, 94, 112, 129, and it is 133 for every count from 4 on.
- R4: With two data lines the ceiling in MHz for counts 0 to 6 is 94, 79, 97, 106, 115, 125, 133, and it is 94 for every count from 7 on.
- R5: With four data lines the ceiling in MHz for counts 0 to 7 is 133, 44, 61, 78, 97, 106, 115, 125, and it is 133 for every count from 8 on.
- R6: If the selected ceiling in Hz is at or above `SYS_FREQ_HZ`, `clk_o` follows `clk_i` in both phases and `pass_o` is 1; otherwise `pass_o` is 0 and `clk_o` is divided by N, the smallest integer with `SYS_FREQ_HZ`/N not above the ceiling.
- R7: A divided period lasts N system cycles and starts with its high phase; the high phase lasts floor(N/2) cycles and the low phase ceil(N/2) cycles.
- R8: A change of the enables or of `dummy_i` takes effect only at the end of the output period in progress; that period completes with its old length.
- R9: Reset is active high and sampled on the rising edge of `clk_i`; while it is held, `clk_o` and `pass_o` are 0, and the first rising clock edge after release starts a new period whose output goes high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, frequency given by `SYS_FREQ_HZ` |
| rst_i | input | 1 | Synchronous reset, active high |
| single_en_i | input | 1 | Selects one data line; overrides `dual_en_i` |
| dual_en_i | input | 1 | Selects two data lines when `single_en_i` is low |
| dummy_i | input | 4 | Dummy-cycle count of the read command, 0 to 14 |
| clk_o | output | 1 | Generated serial clock |
| pass_o | output | 1 | High while `clk_o` is the undivided system clock |

## Verification
The divided output and the flag are registered, so a setting takes hold on the first rising edge that ends the running period, at most N old cycles after the change, and the bench waits well past the longest such period before it queues an expected item. The monitor samples the output on falling edges, where the registered value is stable, and measures a whole period from one rising transition to the next; in pass-through mode it instead samples a quarter period after each edge, where `clk_o` must equal the clock phase. The boundary rule is checked cycle by cycle: the bench switches setting in the cycle right after a rising transition and expects the exact sequence of samples that finishing the old period and then starting the new one gives.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    localparam int BUS_MODES = 3;
    localparam int DUMMY_W   = 4;
    localparam int DUMMY_TOP = 14;

    typedef enum logic [1:0] {
        BUS_X1 = 2'd0,
        BUS_X2 = 2'd1,
        BUS_X4 = 2'd2
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e          mode;
        logic [DUMMY_W-1:0] dummy;
    } clk_sel_t;

    // Ceiling of the serial clock in MHz for a bus width and dummy count.
    function automatic int ceil_mhz(input int mode, input int dummy);
        int r;
        r = 133;
        case (mode)
            0: begin
                case (dummy)
                    0:       r = 133;
                    1:       r = 94;
                    2:       r = 112;
                    3:       r = 129;
                    default: r = 133;
                endcase
            end
            1: begin
                case (dummy)
                    0:       r = 94;
                    1:       r = 79;
                    2:       r = 97;
                    3:       r = 106;
                    4:       r = 115;
                    5:       r = 125;
                    6:       r = 133;
                    default: r = 94;
                endcase
            end
            default: begin
                case (dummy)
                    0:       r = 133;
                    1:       r = 44;
                    2:       r = 61;
                    3:       r = 78;
                    4:       r = 97;
                    5:       r = 106;
                    6:       r = 115;
                    7:       r = 125;
                    default: r = 133;
                endcase
            end
        endcase
        return r;
    endfunction

    // Smallest divider keeping sys_hz / n at or below the ceiling; 1 means pass-through.
    function automatic longint div_ratio(input longint sys_hz, input int lim_mhz);
        longint lim_hz;
        lim_hz = longint'(lim_mhz) * 64'sd1000000;
        if (lim_hz >= sys_hz) begin
            return 64'sd1;
        end
        return (sys_hz + lim_hz - 64'sd1) / lim_hz;
    endfunction

endpackage

// File: rtl/spiclk_mode_sel.sv
module spiclk_mode_sel
    import spiclk_pkg::*;
(
    input  logic               single_en_i,
    input  logic               dual_en_i,
    input  logic [DUMMY_W-1:0] dummy_i,
    output clk_sel_t           sel_o
);

    always_comb begin
        if (single_en_i) begin
            sel_o.mode = BUS_X1;
        end else if (dual_en_i) begin
            sel_o.mode = BUS_X2;
        end else begin
            sel_o.mode = BUS_X4;
        end

        if (dummy_i > DUMMY_W'(DUMMY_TOP)) begin
            sel_o.dummy = DUMMY_W'(DUMMY_TOP);
        end else begin
            sel_o.dummy = dummy_i;
        end
    end

endmodule

// File: rtl/spiclk_ratio_lut.sv
module spiclk_ratio_lut
    import spiclk_pkg::*;
#(
    parameter longint SYS_FREQ_HZ = 100_000_000,
    parameter int     RATIO_W     = 16
) (
    input  clk_sel_t           sel_i,
    output logic [RATIO_W-1:0] ratio_o
);

    localparam int DUMMY_N = DUMMY_TOP + 1;

    logic [RATIO_W-1:0] tab [BUS_MODES][DUMMY_N];

    for (genvar m = 0; m < BUS_MODES; m++) begin : g_mode
        for (genvar d = 0; d < DUMMY_N; d++) begin : g_dummy
            localparam longint ENTRY = div_ratio(SYS_FREQ_HZ, ceil_mhz(m, d));
            assign tab[m][d] = RATIO_W'(ENTRY);
        end
    end

    always_comb begin
        ratio_o = RATIO_W'(1);
        for (int m = 0; m < BUS_MODES; m++) begin
            for (int d = 0; d < DUMMY_N; d++) begin
                if ((2'(sel_i.mode) == 2'(m)) && (sel_i.dummy == DUMMY_W'(d))) begin
                    ratio_o = tab[m][d];
                end
            end
        end
    end

endmodule

// File: rtl/spiclk_divider.sv
module spiclk_divider #(
    parameter int RATIO_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               div_q,
    output logic               pass_q,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [RATIO_W-1:0] phase_cnt
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic               at_end;
    logic [RATIO_W-1:0] nxt_ratio;
    logic [RATIO_W-1:0] nxt_cnt;
    logic [RATIO_W-1:0] nxt_high;

    always_comb begin
        at_end = (phase_cnt == (cur_ratio - ONE));
        if (at_end) begin
            nxt_ratio = (ratio_i == '0) ? ONE : ratio_i;
            nxt_cnt   = '0;
        end else begin
            nxt_ratio = cur_ratio;
            nxt_cnt   = phase_cnt + ONE;
        end
        nxt_high = nxt_ratio >> 1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_ratio <= ONE;
            phase_cnt <= '0;
            div_q     <= 1'b0;
            pass_q    <= 1'b0;
        end else begin
            cur_ratio <= nxt_ratio;
            phase_cnt <= nxt_cnt;
            div_q     <= (nxt_cnt < nxt_high);
            pass_q    <= (nxt_ratio == ONE);
        end
    end

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter longint SYS_FREQ_HZ = 100_000_000,
    parameter int     RATIO_W     = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               single_en_i,
    input  logic               dual_en_i,
    input  logic [DUMMY_W-1:0] dummy_i,
    output logic               clk_o,
    output logic               pass_o
);

    clk_sel_t           sel;
    logic [RATIO_W-1:0] want_ratio;
    logic [RATIO_W-1:0] cur_ratio;
    logic [RATIO_W-1:0] phase_cnt;
    logic               div_q;
    logic               pass_q;

    spiclk_mode_sel u_sel (
        .single_en_i (single_en_i),
        .dual_en_i   (dual_en_i),
        .dummy_i     (dummy_i),
        .sel_o       (sel)
    );

    spiclk_ratio_lut #(
        .SYS_FREQ_HZ (SYS_FREQ_HZ),
        .RATIO_W     (RATIO_W)
    ) u_lut (
        .sel_i   (sel),
        .ratio_o (want_ratio)
    );

    spiclk_divider #(
        .RATIO_W (RATIO_W)
    ) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ratio_i   (want_ratio),
        .div_q     (div_q),
        .pass_q    (pass_q),
        .cur_ratio (cur_ratio),
        .phase_cnt (phase_cnt)
    );

    assign clk_o  = pass_q ? clk_i : div_q;
    assign pass_o = pass_q;

endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk #(
    parameter int RATIO_W = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               pass_o,
    input logic               div_q,
    input logic [RATIO_W-1:0] cur_ratio,
    input logic [RATIO_W-1:0] phase_cnt
);

    AST_RST_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!pass_o && !div_q)); // R9

    AST_PASS_UNITY: assert property (@(posedge clk_i) disable iff (rst_i)
        pass_o |-> (cur_ratio == RATIO_W'(1) && !div_q)); // R6

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_cnt != '0) |-> $stable(cur_ratio)); // R8

    AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_cnt < cur_ratio)); // R7

    AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(div_q) |-> (phase_cnt == '0)); // R7

endmodule

bind spiclk_gen spiclk_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pass_o    (pass_o),
    .div_q     (div_q),
    .cur_ratio (cur_ratio),
    .phase_cnt (phase_cnt)
);

// File: tb/spiclk_gen_bench.sv
module spiclk_gen_bench;

    localparam longint SYS_HZ = 100_000_000;

    typedef struct {
        string tag;
        int    ratio;
        bit    pass;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_en = 1'b1;
    logic       d_en = 1'b0;
    logic [3:0] dcnt = 4'd0;
    logic       clk_o;
    logic       pass_o;

    int n_chk  = 0;
    int n_fail = 0;
    int pushed = 0;
    int done_n = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    spiclk_gen #(.SYS_FREQ_HZ(SYS_HZ)) u_spiclk_gen (
        .clk_i       (clk),
        .rst_i       (rst),
        .single_en_i (s_en),
        .dual_en_i   (d_en),
        .dummy_i     (dcnt),
        .clk_o       (clk_o),
        .pass_o      (pass_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ceilings per the requirements: mode 0 one line, 1 two lines, 2 four lines.
    function automatic int lim_of(input int mode, input int dummy);
        int d;
        int one_l [4]   = '{133, 94, 112, 129};
        int two_l [7]   = '{94, 79, 97, 106, 115, 125, 133};
        int four_l [8]  = '{133, 44, 61, 78, 97, 106, 115, 125};
        d = (dummy > 14) ? 14 : dummy;
        if (mode == 0) return (d < 4) ? one_l[d] : 133;
        if (mode == 1) return (d < 7) ? two_l[d] : 94;
        return (d < 8) ? four_l[d] : 133;
    endfunction

    function automatic int ratio_of(input int mode, input int dummy);
        longint lim;
        lim = longint'(lim_of(mode, dummy)) * 1000000;
        if (lim >= SYS_HZ) return 1;
        return int'((SYS_HZ + lim - 1) / lim);
    endfunction

    task automatic apply(input bit s, input bit d, input int dc, input string tag);
        int mode;
        exp_t it;
        @(negedge clk); #2;
        s_en = s; d_en = d; dcnt = 4'(dc);
        repeat (10) @(negedge clk);
        mode = s ? 0 : (d ? 1 : 2);
        it.tag   = tag;
        it.ratio = ratio_of(mode, dc);
        it.pass  = (it.ratio == 1);
        sb_q.push_back(it);
        pushed++;
        wait (done_n == pushed);
    endtask

    // Monitor: pops expected items and measures the output.
    initial begin
        exp_t it;
        int prev, cur, hi, lo, guard;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            if (it.pass) begin
                @(posedge clk); #5;
                check(pass_o === 1'b1, {it.tag, " R6 flag"}, int'(pass_o), 1);
                check(clk_o === 1'b1, {it.tag, " R6 high phase"}, int'(clk_o), 1);
                @(negedge clk); #5;
                check(clk_o === 1'b0, {it.tag, " R6 low phase"}, int'(clk_o), 0);
            end else begin
                @(negedge clk);
                check(pass_o === 1'b0, {it.tag, " R6 flag"}, int'(pass_o), 0);
                prev = int'(clk_o);
                cur = prev;
                guard = 0;
                while (guard < 40) begin
                    @(negedge clk);
                    cur = int'(clk_o);
                    if (prev == 0 && cur == 1) break;
                    prev = cur;
                    guard++;
                end
                hi = 1; lo = 0;
                @(negedge clk);
                while (clk_o === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
                while (clk_o === 1'b0 && lo < 40) begin lo++; @(negedge clk); end
                check(hi + lo == it.ratio, {it.tag, " R7 period"}, hi + lo, it.ratio);
                check(hi == it.ratio / 2, {it.tag, " R7 high"}, hi, it.ratio / 2);
            end
            done_n++;
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int seq[5];
        int exp_seq[5] = '{0, 0, 1, 0, 1};
        int first[4];
        int exp_first[4] = '{1, 0, 0, 1};

        // R9: held in reset with a pass-through setting selected.
        repeat (3) @(posedge clk);
        #5;
        check(clk_o === 1'b0 && pass_o === 1'b0, "R9 reset outputs", int'({clk_o, pass_o}), 0);
        @(negedge clk); #5;
        check(clk_o === 1'b0, "R9 reset low", int'(clk_o), 0);

        // R9: release with four lines, 1 dummy (ratio 3); output rises on first edge.
        @(negedge clk); #2;
        s_en = 1'b0; d_en = 1'b0; dcnt = 4'd1;
        @(negedge clk); #2;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            first[i] = int'(clk_o);
        end
        for (int i = 0; i < 4; i++) begin
            check(first[i] == exp_first[i], "R9 first period", first[i], exp_first[i]);
        end

        // R3: one data line.
        apply(1, 0, 0,  "R3 x1 d0");
        apply(1, 0, 1,  "R3 x1 d1");
        apply(1, 0, 2,  "R3 x1 d2");
        apply(1, 0, 3,  "R3 x1 d3");
        apply(1, 0, 9,  "R3 x1 d9");
        // R4: two data lines.
        apply(0, 1, 0,  "R4 x2 d0");
        apply(0, 1, 2,  "R4 x2 d2");
        apply(0, 1, 3,  "R4 x2 d3");
        apply(0, 1, 6,  "R4 x2 d6");
        apply(0, 1, 7,  "R4 x2 d7");
        apply(0, 1, 14, "R4 x2 d14");
        // R5: four data lines.
        apply(0, 0, 0,  "R5 x4 d0");
        apply(0, 0, 1,  "R5 x4 d1");
        apply(0, 0, 2,  "R5 x4 d2");
        apply(0, 0, 4,  "R5 x4 d4");
        apply(0, 0, 5,  "R5 x4 d5");
        apply(0, 0, 8,  "R5 x4 d8");
        // R1: both enables high behave as one line (d0 passes, two lines would divide).
        apply(1, 1, 0,  "R1 both enables");
        // R2: count 15 behaves as 14.
        apply(0, 0, 15, "R2 x4 d15");
        apply(0, 1, 15, "R2 x2 d15");

        // R8: switch from ratio 3 to ratio 2 right after a rising transition.
        apply(0, 0, 1,  "R8 setup");
        begin
            int p, c, g;
            @(negedge clk);
            p = int'(clk_o);
            g = 0;
            while (g < 20) begin
                @(negedge clk);
                c = int'(clk_o);
                if (p == 0 && c == 1) break;
                p = c;
                g++;
            end
            #2;
            s_en = 1'b0; d_en = 1'b1; dcnt = 4'd0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                seq[i] = int'(clk_o);
            end
            for (int i = 0; i < 5; i++) begin
                check(seq[i] == exp_seq[i], "R8 boundary switch", seq[i], exp_seq[i]);
            end
        end

        // R9: reset asserted mid-run holds the output low.
        @(negedge clk); #2;
        rst = 1'b1;
        @(posedge clk); #5;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(clk_o === 1'b0 && pass_o === 1'b0, "R9 mid-run reset", int'({clk_o, pass_o}), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule